// File: doc/BRIEF.md
# Key-Sequence Controlled Watchdog Timer

This peripheral is a watchdog that leaves reset already armed and counting up from a fixed load value in its own counter clock domain. When the count wraps past its all-ones value it raises a one-cycle reset-request pulse and reloads, so a system that ignores it is reset periodically. Software reaches it over a small register bus with address, write data, write enable and combinational read data, all in the bus clock domain.

Software can stop the timer only with an ordered pair of key writes to the key register. A second ordered pair starts it again. Key writes are posted. Each one is handed to the counter domain through a toggle handshake, and a pending flag stays high until the counter domain has acknowledged it. A soft-reset command re-arms and reloads the timer. A reset-done flag shows when the soft reset has finished.

Top module: `wdt_keyed`

## Requirements
- R1: After hardware reset the timer is running. The status register (offset 0x14, bit 0) reads 1 and the pending register (offset 0x34) reads 0. The first reset-request pulse comes 2^32 − LOAD_VAL counter cycles after reset is released, give or take two cycles.
- R2: A running timer produces a reset-request pulse that is exactly one counter cycle wide. The pulses are exactly 2^32 − LOAD_VAL counter cycles apart, because the count reloads LOAD_VAL on each wrap.
- R3: A write to the key register (offset 0x48, key in bits 15:0) sets the pending register to 0x10 (bit 4) from the next bus cycle. Pending falls back to 0 after the handshake round trip, which is more than two and fewer than twenty bus cycles. All other pending-register bits read 0.
- R4: A key write that arrives while pending is high is dropped and does not touch the key sequence.
- R5: Writing 0xAAAA and then 0x5555 as consecutive accepted key writes stops the timer. No reset-request pulse follows.
- R6: The timer keeps running in either of two cases: a 0x5555 arrives without a directly preceding 0xAAAA, or another value comes between 0xAAAA and 0x5555. Any non-matching value clears the sequence state.
- R7: Writing 0xBBBB and then 0x4444 as consecutive accepted key writes starts the timer again and reloads LOAD_VAL. The next pulse follows a full period after the 0x4444 takes effect.
- R8: Writing 1 to bit 1 of the control register (offset 0x10) starts a soft reset. The status bit then reads 0 for exactly SRST_CYCLES (8) bus cycles and reads 1 again after that. Afterwards the timer is running and reloaded, even if it was stopped, and the key sequence is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| cnt_clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset for both domains |
| addr_i | input | ADDR_W | Byte address of the register access |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write enable, one bus cycle per write |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| wdt_rst_req_o | output | 1 | One-cycle reset request on expiry, counter domain |

## Verification
The case that is hardest to reach from the ports is a key write that lands while the previous one is still crossing between the clock domains. A well-behaved driver always waits for pending to clear, so this never happens in normal use. The bench therefore issues 0xAAAA and then 0x5555 on back-to-back bus cycles. If the second write is dropped correctly, the timer keeps running and the sequence stays half-armed, so a single later 0x5555 then stops it. The random phase draws key values from a weighted pool so that partial, broken and repeated sequences occur often. A bench model predicts whether the timer runs, and the bench confirms it by watching for a pulse across one full period.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int KEY_W    = 16;
  localparam int OFS_CTRL = 'h10;
  localparam int OFS_STAT = 'h14;
  localparam int OFS_PEND = 'h34;
  localparam int OFS_KEY  = 'h48;
  localparam int PEND_BIT = 4;
  localparam int SRST_BIT = 1;

  localparam logic [KEY_W-1:0] KEY_STOP_A  = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_STOP_B  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_START_A = 16'hBBBB;
  localparam logic [KEY_W-1:0] KEY_START_B = 16'h4444;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_STOP1  = 2'd1,
    SEQ_START1 = 2'd2
  } seq_e;

  typedef struct packed {
    seq_e nxt;
    logic stop;
    logic start;
  } seq_res_t;

  // One step of the key-sequence recogniser for one applied key.
  function automatic seq_res_t seq_step(input seq_e cur, input logic [KEY_W-1:0] key);
    seq_res_t r;
    r.nxt   = SEQ_IDLE;
    r.stop  = 1'b0;
    r.start = 1'b0;
    if (key == KEY_STOP_A) begin
      r.nxt = SEQ_STOP1;
    end else if (key == KEY_START_A) begin
      r.nxt = SEQ_START1;
    end else if (key == KEY_STOP_B) begin
      r.stop = (cur == SEQ_STOP1);
    end else if (key == KEY_START_B) begin
      r.start = (cur == SEQ_START1);
    end
    return r;
  endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/wdt_bus_regs.sv
module wdt_bus_regs #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SRST_CYCLES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic                     we_i,
  output logic [DATA_W-1:0]        rdata_o,
  input  logic                     ack_tgl_s,
  output logic                     req_tgl,
  output logic [wdt_pkg::KEY_W-1:0] key_q,
  output logic                     pending,
  output logic                     key_accept,
  output logic                     srst_wr,
  output logic                     srst_busy,
  output logic                     done
);
  import wdt_pkg::*;

  localparam int BW = $clog2(SRST_CYCLES + 1);

  logic [BW-1:0] busy_cnt;
  logic          sel_key, sel_ctrl, sel_stat, sel_pend;

  assign sel_key  = (addr_i == ADDR_W'(OFS_KEY));
  assign sel_ctrl = (addr_i == ADDR_W'(OFS_CTRL));
  assign sel_stat = (addr_i == ADDR_W'(OFS_STAT));
  assign sel_pend = (addr_i == ADDR_W'(OFS_PEND));

  assign pending    = req_tgl ^ ack_tgl_s;
  assign key_accept = we_i && sel_key && !pending;
  assign srst_wr    = we_i && sel_ctrl && wdata_i[SRST_BIT];
  assign srst_busy  = (busy_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl <= 1'b0;
      key_q   <= '0;
    end else if (key_accept) begin
      req_tgl <= ~req_tgl;
      key_q   <= wdata_i[KEY_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      done     <= 1'b1;
    end else if (srst_wr) begin
      busy_cnt <= BW'(SRST_CYCLES);
      done     <= 1'b0;
    end else if (srst_busy) begin
      busy_cnt <= busy_cnt - 1'b1;
      if (busy_cnt == BW'(1)) done <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_pend) rdata_o[PEND_BIT] = pending;
    if (sel_stat) rdata_o[0]        = done;
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int              CNT_W    = 32,
  parameter logic [CNT_W-1:0] LOAD_VAL = 32'hFFFF_0000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_tgl_s,
  input  logic [wdt_pkg::KEY_W-1:0] key_q,
  input  logic                      srst_s,
  output logic                      ack_tgl,
  output logic                      key_apply,
  output logic                      en,
  output logic [CNT_W-1:0]          cnt,
  output logic                      rst_req
);
  import wdt_pkg::*;

  seq_e     seq;
  seq_res_t step;
  logic     wrap;

  assign key_apply = req_tgl_s ^ ack_tgl;
  assign step      = seq_step(seq, key_q);
  assign wrap      = &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_tgl <= 1'b0;
    else        ack_tgl <= req_tgl_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b1;
      cnt     <= LOAD_VAL;
      seq     <= SEQ_IDLE;
      rst_req <= 1'b0;
    end else if (srst_s) begin
      en      <= 1'b1;
      cnt     <= LOAD_VAL;
      seq     <= SEQ_IDLE;
      rst_req <= 1'b0;
    end else if (key_apply && step.stop) begin
      en      <= 1'b0;
      seq     <= step.nxt;
      rst_req <= 1'b0;
    end else if (key_apply && step.start) begin
      en      <= 1'b1;
      cnt     <= LOAD_VAL;
      seq     <= step.nxt;
      rst_req <= 1'b0;
    end else begin
      if (key_apply) seq <= step.nxt;
      rst_req <= en && wrap;
      if (en) cnt <= wrap ? LOAD_VAL : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int               ADDR_W      = 8,
  parameter int               DATA_W      = 32,
  parameter int               CNT_W       = 32,
  parameter logic [CNT_W-1:0] LOAD_VAL    = 32'hFFFF_0000,
  parameter int               SRST_CYCLES = 8,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              cnt_clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wdt_rst_req_o
);
  import wdt_pkg::*;

  logic             req_tgl, req_tgl_s, ack_tgl, ack_tgl_s;
  logic [KEY_W-1:0] key_q;
  logic             pending, key_accept, srst_wr, srst_busy, done;
  logic             srst_s, key_apply, en;
  logic [CNT_W-1:0] cnt;

  wdt_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRST_CYCLES(SRST_CYCLES)) regs_i (
    .clk(bus_clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i), .we_i(we_i),
    .rdata_o(rdata_o), .ack_tgl_s(ack_tgl_s), .req_tgl(req_tgl), .key_q(key_q),
    .pending(pending), .key_accept(key_accept), .srst_wr(srst_wr),
    .srst_busy(srst_busy), .done(done)
  );

  wdt_sync #(.STAGES(SYNC_STAGES)) req_sync_i  (.clk(cnt_clk), .rst_n(rst_n), .d(req_tgl),   .q(req_tgl_s));
  wdt_sync #(.STAGES(SYNC_STAGES)) srst_sync_i (.clk(cnt_clk), .rst_n(rst_n), .d(srst_busy), .q(srst_s));
  wdt_sync #(.STAGES(SYNC_STAGES)) ack_sync_i  (.clk(bus_clk), .rst_n(rst_n), .d(ack_tgl),   .q(ack_tgl_s));

  wdt_core #(.CNT_W(CNT_W), .LOAD_VAL(LOAD_VAL)) core_i (
    .clk(cnt_clk), .rst_n(rst_n), .req_tgl_s(req_tgl_s), .key_q(key_q), .srst_s(srst_s),
    .ack_tgl(ack_tgl), .key_apply(key_apply), .en(en), .cnt(cnt), .rst_req(wdt_rst_req_o)
  );
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int               CNT_W    = 32,
  parameter logic [CNT_W-1:0] LOAD_VAL = 32'hFFFF_0000
) (
  input logic             bus_clk,
  input logic             cnt_clk,
  input logic             rst_n,
  input logic             key_accept,
  input logic             pending,
  input logic             srst_wr,
  input logic             done,
  input logic             srst_s,
  input logic             key_apply,
  input logic             en,
  input logic [CNT_W-1:0] cnt,
  input logic             rst_req
);
  // R3
  pend_set_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    key_accept |=> pending);

  // R8
  done_low_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    srst_wr |=> !done);

  // R8
  rearm_chk: assert property (@(posedge cnt_clk) disable iff (!rst_n)
    srst_s |=> (en && !rst_req && cnt == LOAD_VAL));

  // R2
  pulse_width_chk: assert property (@(posedge cnt_clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R2
  wrap_reload_chk: assert property (@(posedge cnt_clk) disable iff (!rst_n)
    (en && (&cnt) && !srst_s && !key_apply) |=> (rst_req && cnt == LOAD_VAL));

  // R5
  stopped_quiet_chk: assert property (@(posedge cnt_clk) disable iff (!rst_n)
    !en |=> !rst_req);
endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W), .LOAD_VAL(LOAD_VAL)) chk_i (
  .bus_clk(bus_clk), .cnt_clk(cnt_clk), .rst_n(rst_n), .key_accept(key_accept),
  .pending(pending), .srst_wr(srst_wr), .done(done), .srst_s(srst_s),
  .key_apply(key_apply), .en(en), .cnt(cnt), .rst_req(wdt_rst_req_o)
);

// File: tb/wdt_keyed_tb_top.sv
module wdt_keyed_tb_top;
  localparam logic [31:0] LOAD   = 32'hFFFF_FF00;
  localparam int          PERIOD = 256;

  logic        bus_clk = 1'b0, cnt_clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        we = 1'b0, rreq;

  int checks = 0, errors = 0;
  int pulses = 0, ccyc = 0, last_pulse = 0, prev_pulse = 0, rel_cyc = 0;
  int men = 1, mseq = 0;
  bit finished = 0;

  always #5  bus_clk = ~bus_clk;
  always #10 cnt_clk = ~cnt_clk;

  wdt_keyed #(.LOAD_VAL(LOAD)) dut_i (
    .bus_clk(bus_clk), .cnt_clk(cnt_clk), .rst_n(rst_n), .addr_i(addr),
    .wdata_i(wdata), .we_i(we), .rdata_o(rdata), .wdt_rst_req_o(rreq)
  );

  always @(negedge cnt_clk) begin
    ccyc++;
    if (rreq) begin
      pulses++;
      prev_pulse = last_pulse;
      last_pulse = ccyc;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge bus_clk);
    we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge bus_clk);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    do begin
      bus_read(8'h34, v);
      n++;
    end while (v[4] && n < 50);
  endtask

  // Bench model of the key recogniser: 1 = half of stop seen, 2 = half of start seen.
  task automatic model_key(input logic [15:0] v);
    case (v)
      16'hAAAA: mseq = 1;
      16'hBBBB: mseq = 2;
      16'h5555: begin if (mseq == 1) men = 0; mseq = 0; end
      16'h4444: begin if (mseq == 2) men = 1; mseq = 0; end
      default:  mseq = 0;
    endcase
  endtask

  task automatic key_write(input logic [15:0] v);
    int n;
    bus_write(8'h48, {16'h0, v});
    model_key(v);
    wait_idle(n);
  endtask

  task automatic running(output int got);
    int p0 = pulses;
    repeat (PERIOD + 8) @(negedge cnt_clk);
    got = (pulses != p0) ? 1 : 0;
  endtask

  initial begin
    #(150000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n, got, c0;
    void'($urandom(32'd24680));
    repeat (4) @(negedge bus_clk);
    @(negedge cnt_clk);
    rst_n = 1'b1;
    rel_cyc = ccyc;

    // R1 reset state
    bus_read(8'h14, v); chk("R1 done after reset", v, 32'h1);
    bus_read(8'h34, v); chk("R1 pending after reset", v, 32'h0);
    while (pulses < 3) @(negedge cnt_clk);
    chk("R1 first expiry", ((pulses >= 1) && (last_pulse - rel_cyc - 2 * PERIOD >= PERIOD)
        && (last_pulse - rel_cyc - 2 * PERIOD <= PERIOD + 2)) ? 1 : 0, 1);
    // R2 period and width
    chk("R2 period", last_pulse - prev_pulse, PERIOD);
    @(negedge cnt_clk);
    chk("R2 pulse width", {31'b0, rreq}, 0);

    // R3 pending behaviour
    bus_write(8'h48, 32'h0000_1234); model_key(16'h1234);
    bus_read(8'h34, v); chk("R3 pending set", v, 32'h10);
    wait_idle(n);
    chk("R3 round trip length", (n >= 2 && n < 20) ? 1 : 0, 1);

    // R5 stop sequence
    key_write(16'hAAAA); key_write(16'h5555);
    running(got); chk("R5 stopped", got, 0);

    // R7 restart reloads
    key_write(16'hBBBB); key_write(16'h4444);
    c0 = ccyc; n = pulses;
    while (pulses == n) @(negedge cnt_clk);
    chk("R7 restart interval", (last_pulse - c0 >= PERIOD - 6 && last_pulse - c0 <= PERIOD) ? 1 : 0, 1);

    // R6 broken sequences
    key_write(16'h5555);
    running(got); chk("R6 lone second key", got, 1);
    key_write(16'hAAAA); key_write(16'h1111); key_write(16'h5555);
    running(got); chk("R6 interrupted sequence", got, 1);

    // R4 write while pending is dropped
    bus_write(8'h48, 32'hAAAA); model_key(16'hAAAA);
    bus_write(8'h48, 32'h5555);
    wait_idle(n);
    running(got); chk("R4 dropped write keeps running", got, 1);
    key_write(16'h5555);
    running(got); chk("R4 sequence state kept half-armed", got, 0);

    // R8 soft reset from stopped state
    bus_write(8'h10, 32'h2);
    bus_read(8'h14, v); chk("R8 done low", v, 0);
    repeat (5) @(negedge bus_clk);
    bus_read(8'h14, v); chk("R8 done low at cycle 7", v, 0);
    bus_read(8'h14, v); chk("R8 done high at cycle 8", v, 1);
    men = 1; mseq = 0;
    running(got); chk("R8 rearmed", got, 1);
    key_write(16'h5555);
    running(got); chk("R8 sequence cleared", got, 1);

    // random key streams, R5 R6 R7
    for (int r = 0; r < 14; r++) begin
      for (int k = 0; k < 3; k++) begin
        int pick = $urandom_range(0, 5);
        logic [15:0] kv;
        case (pick)
          0: kv = 16'hAAAA;
          1: kv = 16'h5555;
          2: kv = 16'hBBBB;
          3: kv = 16'h4444;
          default: kv = 16'h1000 | (16'($urandom) & 16'h0FFF);
        endcase
        key_write(kv);
      end
      running(got); chk("R5/R6/R7 random run state", got, men);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule